// File: doc/BRIEF.md
# UART Receive Buffer with Error Flags

This block moves each completed character from an asynchronous receive shift register into a receive buffer register that software can read. It checks the character for three kinds of error at the moment of that move. An overrun means a new character arrived while the buffer still held an unread one. A framing error means a stop bit was sampled low. A parity error means the parity check failed. The block also keeps a summary flag that is set while any of the three errors is present.

The bit sampler delivers a one-cycle `frame_valid` strobe. The strobe carries the data bits, the received parity bit and the sampled stop bits. Software supplies the parity setting, the number of stop bits, the serial mode select field and the receive enable bit. A `rd_lo` strobe marks a read of the low-order byte of the buffer.

The receiver counts as active only while `rx_en` is 1 and `mode_sel` is not 000. While it is inactive, every flag is held clear and every arriving character is dropped.

Top module: `uart_rxb_errflags`

## Requirements
- R1: A character accepted while active is written to `rbuf_data` on the clock edge that samples `frame_valid`, and `rbuf_full` becomes 1 on that same edge. A `rd_lo` with no accepted character on that cycle clears `rbuf_full`.
- R2: An accepted character that does not cause an overrun raises `rx_irq` for exactly the one cycle after the transfer edge.
- R3: An overrun is a character accepted while `rbuf_full` is 1 and `rd_lo` is 0 on the same cycle. It sets `ovr_err`. The new character still overwrites `rbuf_data`, and `rx_irq` stays 0 for that character.
- R4: `stop_cfg` sets the configured stop count N, which is 1 or 2; the value 0 is treated as 1. `frame_stop[i]` is the i-th sampled stop bit, where 1 means valid. If any of bits 0 to N-1 is 0, the transfer sets `frm_err`.
- R5: While `par_en` is 1, `par_err` is set at transfer when the number of 1s across `frame_data` and `frame_par` is odd with `par_odd`=0 (even parity), or even with `par_odd`=1 (odd parity).
- R6: While `par_en` is 0, no transfer sets `par_err`.
- R7: `sum_err` is 1 exactly when at least one of `ovr_err`, `frm_err` or `par_err` is 1. It returns to 0 by itself once all three are 0.
- R8: `rd_lo` clears `frm_err` and `par_err` and leaves `ovr_err` unchanged.
- R9: While `rx_en` is 0 or `mode_sel` is 000, all four flags and `rbuf_full` are cleared. In that state an arriving character changes neither `rbuf_data` nor `rx_irq`.
- R10: If `rd_lo` and an accepted character fall on the same cycle, there is no overrun, the new character's errors are set, and the old framing and parity errors are cleared.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid | input | 1 | One-cycle strobe: a completed character is ready |
| frame_data | input | DATA_W | Received data bits |
| frame_par | input | 1 | Received parity bit |
| frame_stop | input | STOP_MAX | Sampled stop bits, 1 = valid |
| par_en | input | 1 | Enable the parity check |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_cfg | input | SW | Configured stop-bit count |
| mode_sel | input | MODE_W | Serial mode select; all zero disables the receiver |
| rx_en | input | 1 | Receive enable |
| rd_lo | input | 1 | Strobe: low-order byte of the buffer is read |
| rbuf_data | output | DATA_W | Receive buffer contents |
| rbuf_full | output | 1 | Buffer holds an unread character |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| sum_err | output | 1 | Error-sum flag |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
Some rules hold on every cycle, and the assertions check those. Clearing when the receiver goes inactive is one. Overrun staying set across reads, a low-byte read clearing the framing and parity flags, and a new error winning over a same-cycle read are others. The buffer write and the interrupt-or-overrun outcome of each accepted character are also checked every cycle.

The exact parity and stop-bit decisions can only be shown by the bench's scenarios. The bench sweeps every data byte, both parity bit values, every stop pattern and every parity and stop setting. Directed scenarios show the rest. One shows that overwritten data is visible after an overrun. Others show characters dropped while inactive and a stop count of 0 acting as 1.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
        logic sum;
    } rxb_flags_t;
endpackage

// File: rtl/uart_rxb_check.sv
module uart_rxb_check #(
    parameter int DATA_W   = 8,
    parameter int STOP_MAX = 2,
    parameter int SW       = 2
) (
    input  logic [DATA_W-1:0]   data,
    input  logic                par_bit,
    input  logic [STOP_MAX-1:0] stop,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic [SW-1:0]       stop_cfg,
    output logic                frm_bad,
    output logic                par_bad
);
    logic [STOP_MAX-1:0] need;

    // Bit 0 is always required; bit i is required when i < configured count.
    generate
        for (genvar i = 0; i < STOP_MAX; i++) begin : g_need
            if (i == 0) begin : g_first
                assign need[i] = 1'b1;
            end else begin : g_rest
                assign need[i] = (stop_cfg > SW'(i));
            end
        end
    endgenerate

    always_comb begin
        frm_bad = |(need & ~stop);
        par_bad = par_en & (^{data, par_bit, par_odd});
    end
endmodule

// File: rtl/uart_rxb_buffer.sv
module uart_rxb_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              take,
    input  logic              overrun,
    input  logic              rd_lo,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              irq;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = take & ~overrun;
        if (take) st_d.data = data_in;
        if (!active)      st_d.full = 1'b0;
        else if (take)    st_d.full = 1'b1;
        else if (rd_lo)   st_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.full;
    assign irq  = st_q.irq;

    assert_full_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !full);
    assert_irq_needs_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> full);
endmodule

// File: rtl/uart_rxb_flags.sv
module uart_rxb_flags
    import uart_rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       take,
    input  logic       new_ovr,
    input  logic       new_frm,
    input  logic       new_par,
    input  logic       rd_lo,
    output rxb_flags_t flags
);
    rxb_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (!active) begin
            fl_d = '0;
        end else begin
            fl_d.ovr = fl_q.ovr | (take & new_ovr);
            fl_d.frm = (take & new_frm) | (fl_q.frm & ~rd_lo);
            fl_d.par = (take & new_par) | (fl_q.par & ~rd_lo);
        end
        fl_d.sum = fl_d.ovr | fl_d.frm | fl_d.par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    assert_clear_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (flags == '0));
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && flags.ovr) |=> flags.ovr);
    assert_rd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_lo && !take) |=> (!flags.frm && !flags.par));
    assert_new_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && take && new_frm && rd_lo) |=> flags.frm);
endmodule

// File: rtl/uart_rxb_errflags.sv
module uart_rxb_errflags
    import uart_rxb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STOP_MAX = 2,
    parameter int MODE_W   = 3,
    localparam int SW      = $clog2(STOP_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [DATA_W-1:0]   frame_data,
    input  logic                frame_par,
    input  logic [STOP_MAX-1:0] frame_stop,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic [SW-1:0]       stop_cfg,
    input  logic [MODE_W-1:0]   mode_sel,
    input  logic                rx_en,
    input  logic                rd_lo,
    output logic [DATA_W-1:0]   rbuf_data,
    output logic                rbuf_full,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                par_err,
    output logic                sum_err,
    output logic                rx_irq
);
    logic       active, take, overrun, frm_bad, par_bad;
    rxb_flags_t flags;

    assign active  = rx_en & (mode_sel != '0);
    assign take    = frame_valid & active;
    assign overrun = take & rbuf_full & ~rd_lo;

    uart_rxb_check #(.DATA_W(DATA_W), .STOP_MAX(STOP_MAX), .SW(SW)) u_check (
        .data(frame_data), .par_bit(frame_par), .stop(frame_stop),
        .par_en(par_en), .par_odd(par_odd), .stop_cfg(stop_cfg),
        .frm_bad(frm_bad), .par_bad(par_bad)
    );

    uart_rxb_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .active(active), .take(take),
        .overrun(overrun), .rd_lo(rd_lo), .data_in(frame_data),
        .data(rbuf_data), .full(rbuf_full), .irq(rx_irq)
    );

    uart_rxb_flags u_flags (
        .clk(clk), .rst_n(rst_n), .active(active), .take(take),
        .new_ovr(overrun), .new_frm(frm_bad), .new_par(par_bad),
        .rd_lo(rd_lo), .flags(flags)
    );

    assign ovr_err = flags.ovr;
    assign frm_err = flags.frm;
    assign par_err = flags.par;
    assign sum_err = flags.sum;

    assert_buf_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (rbuf_full && rbuf_data == $past(frame_data)));
    assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rbuf_full && !rd_lo) |=> (ovr_err && !rx_irq));
    assert_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(rbuf_full && !rd_lo)) |=> rx_irq);
    assert_sum_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sum_err == (ovr_err | frm_err | par_err));
endmodule

// File: tb/tb_uart_rxb_errflags.sv
`timescale 1ns/1ps
module tb_uart_rxb_errflags;
    logic       clk = 0, rst_n = 0;
    logic       frame_valid = 0, frame_par = 0, par_en = 0, par_odd = 0;
    logic [7:0] frame_data = 0;
    logic [1:0] frame_stop = 2'b11, stop_cfg = 2'd1;
    logic [2:0] mode_sel = 3'b001;
    logic       rx_en = 1, rd_lo = 0;
    logic [7:0] rbuf_data;
    logic       rbuf_full, ovr_err, frm_err, par_err, sum_err, rx_irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    uart_rxb_errflags dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_par(frame_par), .frame_stop(frame_stop), .par_en(par_en),
        .par_odd(par_odd), .stop_cfg(stop_cfg), .mode_sel(mode_sel), .rx_en(rx_en),
        .rd_lo(rd_lo), .rbuf_data(rbuf_data), .rbuf_full(rbuf_full),
        .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err),
        .sum_err(sum_err), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a character (and optional read) for one cycle; return at the following negedge.
    task automatic send(input logic [7:0] d, input logic p, input logic [1:0] s, input logic rd);
        @(negedge clk);
        frame_valid = 1; frame_data = d; frame_par = p; frame_stop = s; rd_lo = rd;
        @(negedge clk);
        frame_valid = 0; rd_lo = 0;
    endtask

    task automatic read_lo();
        @(negedge clk);
        rd_lo = 1;
        @(negedge clk);
        rd_lo = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 full", rbuf_full, 0); chk("R11 data", rbuf_data, 0);
        chk("R11 flags", {ovr_err, frm_err, par_err, sum_err, rx_irq}, 0);
        rst_n = 1;

        // Sweep: parity setting x stop count x data x parity bit; stop pattern varies with data.
        for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
        for (int sc = 1; sc <= 2; sc++)
        for (int d = 0; d < 256; d++)
        for (int pb = 0; pb < 2; pb++) begin
            logic [1:0] s;
            int ef, ep;
            par_en = pe[0]; par_odd = po[0]; stop_cfg = sc[1:0];
            s  = d[1:0] ^ {pb[0], 1'b0};
            ef = (sc == 1) ? int'(!s[0]) : int'(s != 2'b11);
            ep = (pe == 1) ? int'(((($countones(d[7:0]) + pb) % 2) != po)) : 0;
            send(d[7:0], pb[0], s, 1'b0);
            chk("R1 data", rbuf_data, d);
            chk("R1 full", rbuf_full, 1);
            chk("R2 irq", rx_irq, 1);
            chk("R4 frm", frm_err, ef);
            if (pe == 1) chk("R5 par", par_err, ep);
            else         chk("R6 par", par_err, 0);
            chk("R7 sum", sum_err, int'(ef != 0 || ep != 0));
            chk("R3 no ovr", ovr_err, 0);
            @(negedge clk);
            chk("R2 irq one cycle", rx_irq, 0);
            rd_lo = 1;
            @(negedge clk);
            rd_lo = 0;
            chk("R8 frm clr", frm_err, 0); chk("R8 par clr", par_err, 0);
            chk("R1 full clr", rbuf_full, 0); chk("R7 sum clr", sum_err, 0);
        end

        // Overrun
        par_en = 0; stop_cfg = 2'd1;
        send(8'hA5, 0, 2'b11, 0);
        send(8'h3C, 0, 2'b11, 0);
        chk("R3 ovr", ovr_err, 1); chk("R3 data", rbuf_data, 8'h3C);
        chk("R3 no irq", rx_irq, 0); chk("R7 sum", sum_err, 1);
        read_lo();
        chk("R8 ovr kept", ovr_err, 1); chk("R1 full clr", rbuf_full, 0);
        chk("R7 sum held", sum_err, 1);
        @(negedge clk); rx_en = 0;
        @(negedge clk); rx_en = 1;
        chk("R9 ovr clr", ovr_err, 0); chk("R7 sum clr", sum_err, 0);

        // Dropped while inactive
        rx_en = 0;
        send(8'h77, 0, 2'b00, 0);
        chk("R9 data kept", rbuf_data, 8'h3C); chk("R9 no irq", rx_irq, 0);
        chk("R9 no full", rbuf_full, 0); chk("R9 no frm", frm_err, 0);
        rx_en = 1;

        // Mode 000 clears
        send(8'h11, 0, 2'b00, 0);
        chk("R4 frm", frm_err, 1);
        @(negedge clk); mode_sel = 3'b000;
        @(negedge clk); mode_sel = 3'b001;
        chk("R9 mode clr frm", frm_err, 0); chk("R9 mode clr full", rbuf_full, 0);

        // Same-cycle read and new character
        send(8'h01, 0, 2'b00, 0);
        par_en = 1; par_odd = 0;
        send(8'h01, 0, 2'b11, 1);
        chk("R10 no ovr", ovr_err, 0); chk("R10 irq", rx_irq, 1);
        chk("R10 par new", par_err, 1); chk("R10 frm old clr", frm_err, 0);
        chk("R10 full", rbuf_full, 1);
        read_lo();

        // stop_cfg 0 acts as 1
        par_en = 0; stop_cfg = 2'd0;
        send(8'h55, 0, 2'b01, 0);
        chk("R4 cfg0", frm_err, 0);
        read_lo();
        send(8'h55, 0, 2'b10, 0);
        chk("R4 cfg0 bad", frm_err, 1);
        idle();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule